// File: doc/BRIEF.md
# Flash command status controller

This block is the register-side front end of a nonvolatile memory controller. Software reads and writes a small register file over a plain address / write-strobe / data port. The central register is an 8-bit status byte. It holds a command-complete flag, two sticky error flags that are cleared by writing 1, and a read-only view of the command engine's busy bit and 2-bit result. Writing 1 to the command-complete flag hands the pending command to the engine with a one-cycle start strobe. The flag stays low until the engine reports done.

The error flags interlock the launch path. A pending access error or protection violation blocks every launch. A launch request is also checked against an inclusive protected address window and against an illegal-command indication. A failed check raises the matching error flag instead of starting the engine. A separate pair of fault flags records single-bit and double-bit read faults. Each has its own interrupt enable and its own interrupt request.

Top module: `nvm_cmd_status`

## Requirements
- R1: After reset the status byte reads 0x80, both fault registers read 0, the low bound reads 0xFF, the high bound reads 0x00 (an empty window), `eng_start` is 0 and both interrupt requests are 0.
- R2: Status byte layout (address 0): bit 7 complete flag, bit 5 access error, bit 4 protection violation, bit 3 mirrors `eng_busy`, bits 1:0 mirror `eng_result`. Bits 6 and 2 read 0. Bus writes to bits 6, 3, 2, 1 and 0 have no effect.
- R3: A status write with bit 7 = 1 is accepted when all of these hold before the write: the complete flag is 1, the access error is 0, the protection violation is 0, `cmd_illegal` is 0, and the command is not a protection hit. An accepted write clears the complete flag at the same clock edge. `eng_start` is then 1 for exactly the one following cycle.
- R4: The complete flag is set again at the clock edge that samples `eng_done` high. It stays 0 until then. `eng_done` has no effect while the flag is already 1.
- R5: The access error is set by a `seq_break` pulse, or by a launch attempt while `cmd_illegal` is 1. That attempt starts nothing and leaves the complete flag at 1. Writing 1 to bit 5 clears the flag, and writing 0 leaves it unchanged. A set and a clear in the same cycle leave it set.
- R6: A launch attempt with `cmd_modify` = 1 and `low <= cmd_addr <= high` sets the protection violation, starts nothing and leaves the complete flag at 1. Writing 1 to bit 4 clears the flag, and writing 0 leaves it unchanged.
- R7: While the access error or the protection violation is 1, a status write with bit 7 = 1 neither clears the complete flag nor pulses `eng_start`.
- R8: A single write that sets bit 7 and also clears the pending error flags clears those flags but starts no command. The launch decision uses the flag values from before the write.
- R9: `seq_open` (permission to begin a command write sequence) is 1 exactly when the complete flag is 1 and the protection violation is 0.
- R10: `fault_sb` and `fault_db` pulses set fault flags at address 2, bit 0 and bit 1. Each flag is cleared by writing 1 to its bit, and a set wins over a clear in the same cycle. The enables sit at address 1, bits 0 and 1. `irq_sb` and `irq_db` are each the AND of the flag and its enable.
- R11: The low bound (address 3) and the high bound (address 4) are written and read back in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| eng_start | output | 1 | One-cycle start strobe to the command engine |
| eng_done | input | 1 | Command finished pulse |
| eng_busy | input | 1 | Engine busy level |
| eng_result | input | 2 | Engine result code |
| seq_break | input | 1 | Command write sequence was broken |
| cmd_illegal | input | 1 | Pending command code is illegal |
| cmd_modify | input | 1 | Pending command programs or erases |
| cmd_addr | input | 8 | Target address of the pending command |
| fault_sb | input | 1 | Single-bit read fault detected |
| fault_db | input | 1 | Double-bit read fault detected |
| seq_open | output | 1 | A command write sequence may begin |
| irq_sb | output | 1 | Single-bit fault interrupt request |
| irq_db | output | 1 | Double-bit fault interrupt request |

## Verification
The launch path is driven with clean launches, launches blocked by either error flag, launches that clear the errors in the same write, illegal-command launches, and protected launches with the address at the low bound, at the high bound and one step outside each bound. Together these separate a gate that reads the old flag values from one that reads the new ones, and an inclusive compare from an exclusive one. Done pulses arrive both while a command runs and while the block is idle, which shows whether completion is gated by the flag. Write-one-to-clear traffic with 0s, with 1s and with a simultaneous set event tells a real clear-on-one from a plain register write, and tells a set-wins priority from a clear-wins one.

// File: rtl/nvm_stat_pkg.sv
// Package nvm_stat_pkg
// Register addresses and status bit positions shared by the controller,
// its checker and its submodules. Bit positions are fixed because software
// decodes the status byte.
package nvm_stat_pkg;
    localparam int unsigned REG_AW = 3;
    localparam logic [REG_AW-1:0] A_STATUS = 3'd0;
    localparam logic [REG_AW-1:0] A_FEN    = 3'd1;
    localparam logic [REG_AW-1:0] A_FFLAG  = 3'd2;
    localparam logic [REG_AW-1:0] A_LOW    = 3'd3;
    localparam logic [REG_AW-1:0] A_HIGH   = 3'd4;

    localparam int unsigned B_DONE = 7;
    localparam int unsigned B_ACC  = 5;
    localparam int unsigned B_PROT = 4;
    localparam int unsigned B_BUSY = 3;

    localparam int unsigned N_FAULT = 2;
endpackage

// File: rtl/nvm_range_hit.sv
// Module nvm_range_hit
// Inclusive window compare: hit when low <= addr <= high.
// Assumes low > high encodes an empty window (never hits).
module nvm_range_hit #(
    parameter int unsigned AW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] low,
    input  logic [AW-1:0] high,
    output logic          hit
);
    // Both bound compares are inclusive.
    always_comb begin
        hit = (addr >= low) && (addr <= high);
    end
endmodule

// File: rtl/nvm_launch_gate.sv
// Module nvm_launch_gate
// Decides the fate of a launch request: accept, reject with access error,
// or reject with protection violation. Purely combinational. Uses only the
// flag values held before the current write.
module nvm_launch_gate #(
    parameter int unsigned AW = 8
) (
    input  logic          req,
    input  logic          done_flag,
    input  logic          acc_flag,
    input  logic          prot_flag,
    input  logic          illegal,
    input  logic          modify,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] low,
    input  logic [AW-1:0] high,
    output logic          accept,
    output logic          rej_acc,
    output logic          rej_prot
);
    logic hit;
    logic eligible;

    nvm_range_hit #(.AW(AW)) u_hit (
        .addr (addr),
        .low  (low),
        .high (high),
        .hit  (hit)
    );

    // Classify the request by priority: illegal code, then protection.
    always_comb begin
        eligible = req && done_flag && !acc_flag && !prot_flag;
        rej_acc  = eligible && illegal;
        rej_prot = eligible && !illegal && modify && hit;
        accept   = eligible && !illegal && !(modify && hit);
    end
endmodule

// File: rtl/nvm_fault_irq.sv
// Module nvm_fault_irq
// Sticky fault flags with write-one-to-clear and per-flag interrupt enables.
// Assumes the caller decodes the enable and flag register writes. A set
// event wins over a clear in the same cycle.
module nvm_fault_irq #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         wr_en,
    input  logic         wr_flag,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] en_q,
    output logic [N-1:0] flag_q,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_fault
        // Hold the flag and the enable for fault source i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
                en_q[i]   <= 1'b0;
            end else begin
                if (evt[i])
                    flag_q[i] <= 1'b1;
                else if (wr_flag && wdata[i])
                    flag_q[i] <= 1'b0;
                if (wr_en)
                    en_q[i] <= wdata[i];
            end
        end

        // Raise the interrupt request while flag and enable are both set.
        always_comb begin
            irq[i] = flag_q[i] && en_q[i];
        end
    end
endmodule

// File: rtl/nvm_cmd_status.sv
// Module nvm_cmd_status
// Status register and launch interlock for a nonvolatile memory command
// engine. Assumes the engine pulses eng_done once per started command and
// that reads are combinational from reg_addr.
module nvm_cmd_status
    import nvm_stat_pkg::*;
#(
    parameter int unsigned CMD_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              eng_start,
    input  logic              eng_done,
    input  logic              eng_busy,
    input  logic [1:0]        eng_result,
    input  logic              seq_break,
    input  logic              cmd_illegal,
    input  logic              cmd_modify,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic              fault_sb,
    input  logic              fault_db,
    output logic              seq_open,
    output logic              irq_sb,
    output logic              irq_db
);
    localparam logic [CMD_AW-1:0] LOW_RST  = '1;
    localparam logic [CMD_AW-1:0] HIGH_RST = '0;

    logic              done_q, acc_q, prot_q, start_q;
    logic [CMD_AW-1:0] low_q, high_q;
    logic              wr_stat, launch_req;
    logic              accept, rej_acc, rej_prot;
    logic [N_FAULT-1:0] fen_w, fflag_w, firq_w;

    // Decode writes to the status byte and detect a launch request.
    always_comb begin
        wr_stat    = reg_wr && (reg_addr == A_STATUS);
        launch_req = wr_stat && reg_wdata[B_DONE];
    end

    nvm_launch_gate #(.AW(CMD_AW)) u_gate (
        .req       (launch_req),
        .done_flag (done_q),
        .acc_flag  (acc_q),
        .prot_flag (prot_q),
        .illegal   (cmd_illegal),
        .modify    (cmd_modify),
        .addr      (cmd_addr),
        .low       (low_q),
        .high      (high_q),
        .accept    (accept),
        .rej_acc   (rej_acc),
        .rej_prot  (rej_prot)
    );

    // Update the complete flag, the error flags and the start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b1;
            acc_q   <= 1'b0;
            prot_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= accept;
            if (accept)
                done_q <= 1'b0;
            else if (eng_done)
                done_q <= 1'b1;
            if (seq_break || rej_acc)
                acc_q <= 1'b1;
            else if (wr_stat && reg_wdata[B_ACC])
                acc_q <= 1'b0;
            if (rej_prot)
                prot_q <= 1'b1;
            else if (wr_stat && reg_wdata[B_PROT])
                prot_q <= 1'b0;
        end
    end

    // Hold the protected window bounds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= LOW_RST;
            high_q <= HIGH_RST;
        end else if (reg_wr) begin
            if (reg_addr == A_LOW)
                low_q <= reg_wdata[CMD_AW-1:0];
            if (reg_addr == A_HIGH)
                high_q <= reg_wdata[CMD_AW-1:0];
        end
    end

    nvm_fault_irq #(.N(N_FAULT)) u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     ({fault_db, fault_sb}),
        .wr_en   (reg_wr && (reg_addr == A_FEN)),
        .wr_flag (reg_wr && (reg_addr == A_FFLAG)),
        .wdata   (reg_wdata[N_FAULT-1:0]),
        .en_q    (fen_w),
        .flag_q  (fflag_w),
        .irq     (firq_w)
    );

    // Drive the engine and interrupt outputs.
    always_comb begin
        eng_start = start_q;
        seq_open  = done_q && !prot_q;
        irq_sb    = firq_w[0];
        irq_db    = firq_w[1];
    end

    // Select read data for the addressed register.
    always_comb begin
        reg_rdata = 8'h00;
        case (reg_addr)
            A_STATUS: reg_rdata = {done_q, 1'b0, acc_q, prot_q, eng_busy, 1'b0, eng_result};
            A_FEN:    reg_rdata[N_FAULT-1:0] = fen_w;
            A_FFLAG:  reg_rdata[N_FAULT-1:0] = fflag_w;
            A_LOW:    reg_rdata[CMD_AW-1:0] = low_q;
            A_HIGH:   reg_rdata[CMD_AW-1:0] = high_q;
            default:  reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/nvm_cmd_status_chk.sv
// Module nvm_cmd_status_chk
// Temporal checks on the launch interlock and the interrupt gating.
// Attached to every nvm_cmd_status instance through bind.
module nvm_cmd_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       eng_start,
    input logic       eng_done,
    input logic       done_flag,
    input logic       acc_flag,
    input logic       prot_flag,
    input logic       launch_req,
    input logic [1:0] fen,
    input logic       irq_sb,
    input logic       irq_db
);
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    a_r3_strobe_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> !done_flag);

    a_r4_done_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !done_flag) |=> done_flag);

    a_r7_errors_block: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_req && done_flag && (acc_flag || prot_flag)) |=> (!eng_start && done_flag));

    a_r10_sb_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !fen[0] |-> !irq_sb);

    a_r10_db_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !fen[1] |-> !irq_db);
endmodule

bind nvm_cmd_status nvm_cmd_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .eng_start  (eng_start),
    .eng_done   (eng_done),
    .done_flag  (done_q),
    .acc_flag   (acc_q),
    .prot_flag  (prot_q),
    .launch_req (launch_req),
    .fen        (fen_w),
    .irq_sb     (irq_sb),
    .irq_db     (irq_db)
);

// File: tb/tb_nvm_cmd_status.sv
// Bench for nvm_cmd_status: a behavioural reference model updated on every
// rising edge and compared with all outputs at every falling edge, plus
// directed register reads.
module tb_nvm_cmd_status;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       eng_start, eng_done, eng_busy;
    logic [1:0] eng_result;
    logic       seq_break, cmd_illegal, cmd_modify;
    logic [7:0] cmd_addr;
    logic       fault_sb, fault_db;
    logic       seq_open, irq_sb, irq_db;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    string cur_req = "R1";

    // Reference model state
    bit       m_done, m_acc, m_prot, m_start;
    bit [1:0] m_fen, m_fflag;
    bit [7:0] m_low, m_high;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_cmd_status dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
        .eng_done(eng_done), .eng_busy(eng_busy), .eng_result(eng_result),
        .seq_break(seq_break), .cmd_illegal(cmd_illegal), .cmd_modify(cmd_modify),
        .cmd_addr(cmd_addr), .fault_sb(fault_sb), .fault_db(fault_db),
        .seq_open(seq_open), .irq_sb(irq_sb), .irq_db(irq_db)
    );

    // Reference model: next state from the requirements.
    always @(posedge clk) begin
        bit try_launch;
        bit hit;
        if (!rst_n) begin
            m_done = 1; m_acc = 0; m_prot = 0; m_start = 0;
            m_fen = 0; m_fflag = 0; m_low = 8'hFF; m_high = 8'h00;
        end else begin
            bit o_done, o_acc, o_prot;
            o_done = m_done; o_acc = m_acc; o_prot = m_prot;
            m_start = 0;
            try_launch = reg_wr && reg_addr == 0 && reg_wdata[7] && o_done && !o_acc && !o_prot;
            hit = cmd_modify && cmd_addr >= m_low && cmd_addr <= m_high;
            if (reg_wr && reg_addr == 0) begin
                if (reg_wdata[5]) m_acc = 0;
                if (reg_wdata[4]) m_prot = 0;
            end
            if (try_launch) begin
                if (cmd_illegal) m_acc = 1;
                else if (hit) m_prot = 1;
                else begin m_done = 0; m_start = 1; end
            end
            if (seq_break) m_acc = 1;
            if (eng_done && !o_done) m_done = 1;
            for (int i = 0; i < 2; i++) begin
                if (reg_wr && reg_addr == 2 && reg_wdata[i]) m_fflag[i] = 0;
            end
            if (fault_sb) m_fflag[0] = 1;
            if (fault_db) m_fflag[1] = 1;
            if (reg_wr && reg_addr == 1) m_fen = reg_wdata[1:0];
            if (reg_wr && reg_addr == 3) m_low = reg_wdata;
            if (reg_wr && reg_addr == 4) m_high = reg_wdata;
        end
    end

    function automatic logic [7:0] exp_rdata();
        case (reg_addr)
            3'd0: return {m_done, 1'b0, m_acc, m_prot, eng_busy, 1'b0, eng_result};
            3'd1: return {6'd0, m_fen};
            3'd2: return {6'd0, m_fflag};
            3'd3: return m_low;
            3'd4: return m_high;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    // Advance one cycle and compare every output with the model.
    task automatic cyc();
        @(negedge clk);
        check({cur_req, " rdata"}, reg_rdata, exp_rdata());
        check({cur_req, " start"}, {7'd0, eng_start}, {7'd0, m_start});
        check({cur_req, " R9 seq_open"}, {7'd0, seq_open}, {7'd0, m_done && !m_prot});
        check({cur_req, " R10 irq"}, {6'd0, irq_db, irq_sb}, {6'd0, m_fflag & m_fen});
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic rd(input logic [2:0] a, input string req, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic pulse_done();
        eng_done = 1; cyc(); eng_done = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; reg_addr = 0; reg_wr = 0; reg_wdata = 0;
        eng_done = 0; eng_busy = 0; eng_result = 0;
        seq_break = 0; cmd_illegal = 0; cmd_modify = 0; cmd_addr = 0;
        fault_sb = 0; fault_db = 0;
        cyc(); cyc();
        rst_n = 1;
        cyc();
        // R1 reset values
        cur_req = "R1";
        rd(3'd0, "R1 status", 8'h80);
        rd(3'd1, "R1 fen", 8'h00);
        rd(3'd2, "R1 fflag", 8'h00);
        rd(3'd3, "R1 low", 8'hFF);
        rd(3'd4, "R1 high", 8'h00);
        check("R1 start", {7'd0, eng_start}, 8'h00);

        // R2 read-only mirrors and reserved bits
        cur_req = "R2";
        eng_busy = 1; eng_result = 2'b10;
        rd(3'd0, "R2 mirror", 8'h8A);
        wr(3'd0, 8'h4F);
        eng_busy = 0; eng_result = 2'b01;
        rd(3'd0, "R2 write ignored", 8'h81);
        eng_result = 0;

        // R3/R4 accepted launch and completion
        cur_req = "R3";
        wr(3'd0, 8'h80);
        check("R3 start", {7'd0, eng_start}, 8'h01);
        rd(3'd0, "R3 flag low", 8'h00);
        cyc();
        check("R3 strobe one cycle", {7'd0, eng_start}, 8'h00);
        cur_req = "R4";
        cyc(); cyc();
        rd(3'd0, "R4 still running", 8'h00);
        pulse_done();
        rd(3'd0, "R4 done", 8'h80);
        pulse_done();
        rd(3'd0, "R4 idle done", 8'h80);
        // launch while running is ignored
        wr(3'd0, 8'h80); cyc();
        wr(3'd0, 8'h80);
        check("R4 no relaunch while running", {7'd0, eng_start}, 8'h00);
        pulse_done();

        // R5 access error
        cur_req = "R5";
        seq_break = 1; cyc(); seq_break = 0;
        rd(3'd0, "R5 set by seq_break", 8'hA0);
        wr(3'd0, 8'h00);
        rd(3'd0, "R5 write 0 keeps", 8'hA0);
        // R7 blocked launch
        cur_req = "R7";
        wr(3'd0, 8'h80);
        check("R7 acc blocks", {7'd0, eng_start}, 8'h00);
        rd(3'd0, "R7 flag stays", 8'hA0);
        // R8 combined clear + launch
        cur_req = "R8";
        wr(3'd0, 8'hA0);
        check("R8 no start", {7'd0, eng_start}, 8'h00);
        rd(3'd0, "R8 cleared", 8'h80);
        // R5 set wins over clear
        cur_req = "R5";
        seq_break = 1; wr(3'd0, 8'h20); seq_break = 0;
        rd(3'd0, "R5 set wins", 8'hA0);
        wr(3'd0, 8'h20);
        rd(3'd0, "R5 cleared", 8'h80);
        // R5 illegal command
        cmd_illegal = 1; wr(3'd0, 8'h80); cmd_illegal = 0;
        check("R5 illegal no start", {7'd0, eng_start}, 8'h00);
        rd(3'd0, "R5 illegal sets", 8'hA0);
        wr(3'd0, 8'h20);

        // R11 bounds
        cur_req = "R11";
        wr(3'd3, 8'h40); wr(3'd4, 8'h5F);
        rd(3'd3, "R11 low", 8'h40);
        rd(3'd4, "R11 high", 8'h5F);

        // R6 protection window boundaries
        cur_req = "R6";
        cmd_modify = 1; cmd_addr = 8'h40;
        wr(3'd0, 8'h80);
        check("R6 low bound no start", {7'd0, eng_start}, 8'h00);
        rd(3'd0, "R6 low bound hit", 8'h90);
        wr(3'd0, 8'h00);
        rd(3'd0, "R6 write 0 keeps", 8'h90);
        cur_req = "R7";
        wr(3'd0, 8'h80);
        check("R7 prot blocks", {7'd0, eng_start}, 8'h00);
        cur_req = "R6";
        wr(3'd0, 8'h10);
        rd(3'd0, "R6 cleared", 8'h80);
        cmd_addr = 8'h5F; wr(3'd0, 8'h80);
        rd(3'd0, "R6 high bound hit", 8'h90);
        wr(3'd0, 8'h10);
        cmd_addr = 8'h60; wr(3'd0, 8'h80);
        check("R6 above high starts", {7'd0, eng_start}, 8'h01);
        pulse_done();
        cmd_addr = 8'h3F; wr(3'd0, 8'h80);
        check("R6 below low starts", {7'd0, eng_start}, 8'h01);
        pulse_done();
        cmd_modify = 0; cmd_addr = 8'h50; wr(3'd0, 8'h80);
        check("R6 read command in window starts", {7'd0, eng_start}, 8'h01);
        pulse_done();

        // R10 faults
        cur_req = "R10";
        fault_sb = 1; cyc(); fault_sb = 0;
        rd(3'd2, "R10 sb flag", 8'h01);
        check("R10 irq off while disabled", {6'd0, irq_db, irq_sb}, 8'h00);
        wr(3'd1, 8'h03);
        check("R10 irq sb", {6'd0, irq_db, irq_sb}, 8'h01);
        fault_db = 1; wr(3'd2, 8'h02); fault_db = 0;
        rd(3'd2, "R10 db set wins", 8'h03);
        wr(3'd2, 8'h00);
        rd(3'd2, "R10 write 0 keeps", 8'h03);
        wr(3'd2, 8'h01);
        rd(3'd2, "R10 sb cleared", 8'h02);
        wr(3'd1, 8'h00);
        check("R10 db irq disabled", {6'd0, irq_db, irq_sb}, 8'h00);
        cyc(); cyc();

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule